// File: doc/BRIEF.md
# Three-Wire Serial Memory Command Slave

This block is the slave end of a three-wire serial memory link. A host raises chip select and then clocks in a frame on the serial data input, one bit per rising serial-clock edge. The frame holds a start bit, a two-bit command code, an address and, for the storing commands, a data field. The block decodes the frame and acts on a small register array. It can read one location, write one location, erase one location to all ones, fill the whole array with one value, or erase the whole array. It can also open or close a write-enable latch. Read data leaves on the serial output, most significant bit first.

A static organisation input picks byte or 16-bit word access. In byte mode the address field is one bit wider and the data field is 8 bits. In word mode the address field is one bit narrower and the data field is 16 bits. The frame length therefore depends on both the command and the organisation. A parameter builds a half-capacity variant that keeps the same frame but discards the top address bit. The serial pins are sampled in the system clock domain. A serial-clock rise is detected there, so the serial clock must run well below the system clock.

Top module: `mw_serial_mem`

## Requirements
- R1: After reset the serial output is 0, the write-enable latch is closed and every word of the array reads 16'hFFFF.
- R2: Only rising serial-clock edges seen while chip select is high are counted. Edges with the data input at 0 before the start bit (a 1) are ignored.
- R3: A frame is a start bit, a two-bit code sent MSB first (10 read, 01 write, 11 erase one location, 00 special group), the address MSB first, then write data MSB first.
- R4: With `orgWord`=0 the address is ADDR_W bits and the data is 8 bits. Byte address bit 0 = 1 selects bits [15:8] of word (address >> 1), and 0 selects bits [7:0]. With `orgWord`=1 the address is ADDR_W-1 bits and the data is 16 bits.
- R5: For a read, the edge that samples the last address bit sets the output to a dummy 0. Each of the next 8 or 16 edges presents the next data bit, MSB first.
- R6: A write takes effect at the edge that samples the last data bit, which is edge 3+address bits+data bits of the frame.
- R7: Erase of one location sets the addressed byte to 8'hFF or the addressed word to 16'hFFFF.
- R8: In the special group the first two address bits select the command: 11 opens the latch, 00 closes it, 10 erases the whole array, 01 fills it with the data field that follows. The remaining address bits are ignored.
- R9: Fill-all writes every word. In byte mode each word becomes the data byte in both halves.
- R10: While the latch is closed, write, erase, erase-all and fill-all leave the array unchanged.
- R11: Chip select low before the last required edge aborts the frame with no effect. The next frame is decoded from its start bit.
- R12: After a frame completes, further edges are ignored until chip select falls.
- R13: With DECODE_TOP=0 the most significant address bit is ignored in both organisations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csIn | input | 1 | Chip select, active high |
| sclkIn | input | 1 | Serial clock, sampled on clk |
| diIn | input | 1 | Serial data input |
| orgWord | input | 1 | 1 = 16-bit words, 0 = bytes |
| doOut | output | 1 | Serial data output |

## Verification
A wrong bit counter or a wrong phase length shows at the ports within one frame. A read returns bits shifted by one or more places, or a write lands at a neighbouring address. This is caught on the first read-back after that write. A latch stuck open, or a stuck special-group decode, leaves the array changed after a frame that should have had no effect. That shows on the next read of the touched location. Full sweeps of both organisations read back every word and every byte, so a mis-indexed byte half or a wrong address width is found within one pass.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DIN, ST_DOUT, ST_DONE
  } mwState_e;

  typedef enum logic [1:0] {
    OP_SPECIAL = 2'b00,
    OP_WRITE   = 2'b01,
    OP_READ    = 2'b10,
    OP_ERASE   = 2'b11
  } mwOp_e;

  typedef struct packed {
    logic abort;
    logic shiftIn;
    logic loadOut;
    logic shiftOut;
    logic wrOne;
    logic wrAll;
    logic erOne;
    logic erAll;
  } mwStrobe_t;
endpackage

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclkRise,
  input  logic      csIn,
  input  logic      diIn,
  input  logic      orgWord,
  output mwStrobe_t stb
);
  localparam int CNT_W = $clog2(ADDR_W + 17);

  mwState_e         state, stateN;
  logic [CNT_W-1:0] bitCnt, bitCntN, phaseLen;
  logic [1:0]       opcode, opcodeN, sel, selN;
  logic             welQ, welN, lastBit;

  always_comb begin
    unique case (state)
      ST_OPC:  phaseLen = CNT_W'(2);
      ST_ADDR: phaseLen = orgWord ? CNT_W'(ADDR_W - 1) : CNT_W'(ADDR_W);
      ST_DIN,
      ST_DOUT: phaseLen = orgWord ? CNT_W'(16) : CNT_W'(8);
      default: phaseLen = CNT_W'(1);
    endcase
    lastBit = (bitCnt == phaseLen - CNT_W'(1));
  end

  always_comb begin
    stb     = '0;
    stateN  = state;
    bitCntN = bitCnt;
    opcodeN = opcode;
    selN    = sel;
    welN    = welQ;
    if (!csIn) begin
      stb.abort = 1'b1;
      stateN    = ST_IDLE;
      bitCntN   = '0;
    end else if (sclkRise) begin
      bitCntN = lastBit ? '0 : bitCnt + CNT_W'(1);
      unique case (state)
        ST_IDLE: begin
          bitCntN = '0;
          if (diIn) stateN = ST_OPC;
        end
        ST_OPC: begin
          opcodeN = {opcode[0], diIn};
          if (lastBit) stateN = ST_ADDR;
        end
        ST_ADDR: begin
          stb.shiftIn = 1'b1;
          if (bitCnt < CNT_W'(2)) selN = {sel[0], diIn};
          if (lastBit) begin
            stateN = ST_DONE;
            unique case (mwOp_e'(opcode))
              OP_READ: begin
                stb.loadOut = 1'b1;
                stateN      = ST_DOUT;
              end
              OP_WRITE: stateN = ST_DIN;
              OP_ERASE: stb.erOne = welQ;
              default: begin
                unique case (sel)
                  2'b11:   welN = 1'b1;
                  2'b00:   welN = 1'b0;
                  2'b10:   stb.erAll = welQ;
                  default: stateN = ST_DIN;
                endcase
              end
            endcase
          end
        end
        ST_DIN: begin
          stb.shiftIn = 1'b1;
          if (lastBit) begin
            stateN = ST_DONE;
            if (mwOp_e'(opcode) == OP_WRITE) stb.wrOne = welQ;
            else stb.wrAll = welQ;
          end
        end
        ST_DOUT: begin
          stb.shiftOut = 1'b1;
          if (lastBit) stateN = ST_DONE;
        end
        default: bitCntN = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      opcode <= '0;
      sel    <= '0;
      welQ   <= 1'b0;
    end else begin
      state  <= stateN;
      bitCnt <= bitCntN;
      opcode <= opcodeN;
      sel    <= selN;
      welQ   <= welN;
    end
  end

  // R11: chip select low returns the sequencer to its idle state
  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !csIn |=> (state == ST_IDLE && bitCnt == '0));
  // R6: at most one array-changing strobe per edge
  assert_commit_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrOne, stb.wrAll, stb.erOne, stb.erAll}));
  // R2: no frame action without a qualified serial-clock rise
  assert_edge_only_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shiftIn || stb.shiftOut || stb.loadOut) |-> (sclkRise && csIn));
  // R8: the latch only moves on a qualified edge
  assert_wel_edge_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(welQ) |-> $past(sclkRise && csIn));
endmodule

// File: rtl/mw_datapath.sv
module mw_datapath
  import mw_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter bit DECODE_TOP = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  mwStrobe_t stb,
  input  logic      diIn,
  input  logic      orgWord,
  output logic      doOut
);
  localparam int WORD_AW = ADDR_W - 1;
  localparam int DEPTH   = 1 << WORD_AW;
  localparam int SR_W    = ADDR_W + 16;

  logic [SR_W-1:0]    inSr, inNext;
  logic [ADDR_W-1:0]  addrField;
  logic [WORD_AW-1:0] wordIdx;
  logic               hiByte, doQ;
  logic [15:0]        mem [DEPTH];
  logic [15:0]        outSr, rdWord, wrData, wrMask;

  assign inNext = {inSr[SR_W-2:0], diIn};

  always_comb begin
    if (stb.wrOne)
      addrField = orgWord ? {1'b0, inNext[16 +: WORD_AW]} : inNext[8 +: ADDR_W];
    else
      addrField = orgWord ? {1'b0, inNext[0 +: WORD_AW]} : inNext[0 +: ADDR_W];
    if (!DECODE_TOP) begin
      if (orgWord) addrField[WORD_AW-1] = 1'b0;
      else         addrField[ADDR_W-1]  = 1'b0;
    end
    wordIdx = orgWord ? addrField[WORD_AW-1:0] : addrField[ADDR_W-1:1];
    hiByte  = !orgWord && addrField[0];
    rdWord  = mem[wordIdx];
    if (stb.erOne || stb.erAll) wrData = 16'hFFFF;
    else wrData = orgWord ? inNext[15:0] : {inNext[7:0], inNext[7:0]};
    if (orgWord || stb.wrAll || stb.erAll) wrMask = 16'hFFFF;
    else wrMask = hiByte ? 16'hFF00 : 16'h00FF;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inSr  <= '0;
      outSr <= '0;
      doQ   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 16'hFFFF;
    end else begin
      if (stb.shiftIn) inSr <= inNext;
      if (stb.abort) begin
        doQ <= 1'b0;
      end else if (stb.loadOut) begin
        doQ   <= 1'b0;
        outSr <= orgWord ? rdWord : {(hiByte ? rdWord[15:8] : rdWord[7:0]), 8'h00};
      end else if (stb.shiftOut) begin
        doQ   <= outSr[15];
        outSr <= {outSr[14:0], 1'b0};
      end
      if (stb.wrAll || stb.erAll) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= (mem[i] & ~wrMask) | (wrData & wrMask);
      end else if (stb.wrOne || stb.erOne) begin
        mem[wordIdx] <= (mem[wordIdx] & ~wrMask) | (wrData & wrMask);
      end
    end
  end

  assign doOut = doQ;

  // R10: the array holds its contents unless a commit strobe arrives
  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrOne || stb.wrAll || stb.erOne || stb.erAll) |=> $stable(mem[0]));
  // R5: the output only moves on a read step or an abort
  assert_do_steps_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.shiftOut || stb.loadOut || stb.abort) |=> $stable(doQ));
endmodule

// File: rtl/mw_serial_mem.sv
module mw_serial_mem
  import mw_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter bit DECODE_TOP = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic sclkIn,
  input  logic diIn,
  input  logic orgWord,
  output logic doOut
);
  mwStrobe_t stb;
  logic      sclkQ, sclkRise;

  always_ff @(posedge clk) begin
    if (!rstN) sclkQ <= 1'b0;
    else       sclkQ <= sclkIn;
  end
  assign sclkRise = sclkIn && !sclkQ;

  mw_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclkRise(sclkRise), .csIn(csIn),
    .diIn(diIn), .orgWord(orgWord), .stb(stb)
  );

  mw_datapath #(.ADDR_W(ADDR_W), .DECODE_TOP(DECODE_TOP)) i_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .diIn(diIn),
    .orgWord(orgWord), .doOut(doOut)
  );
endmodule

// File: tb/test_mw_serial_mem.sv
module test_mw_serial_mem;
  localparam int ADDR_W = 7;
  localparam int WORDS  = 1 << (ADDR_W - 1);

  logic clk = 1'b0, rstN = 1'b0;
  logic csMain = 1'b0, csNarrow = 1'b0, sclkIn = 1'b0, diIn = 1'b0, orgPin = 1'b1;
  logic doMain, doNarrow, lastDo;
  int   target = 0, nTotal = 0, nFail = 0;
  bit   finished = 1'b0;
  logic [15:0] refMem [WORDS];
  logic        refWel;

  always #5 clk = ~clk;

  mw_serial_mem #(.ADDR_W(ADDR_W), .DECODE_TOP(1'b1)) i_mw_serial_mem (
    .clk(clk), .rstN(rstN), .csIn(csMain), .sclkIn(sclkIn), .diIn(diIn),
    .orgWord(orgPin), .doOut(doMain));

  mw_serial_mem #(.ADDR_W(ADDR_W), .DECODE_TOP(1'b0)) i_mw_serial_mem_narrow (
    .clk(clk), .rstN(rstN), .csIn(csNarrow), .sclkIn(sclkIn), .diIn(diIn),
    .orgWord(orgPin), .doOut(doNarrow));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nTotal++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int aw(input logic org);
    return org ? ADDR_W - 1 : ADDR_W;
  endfunction
  function automatic int dw(input logic org);
    return org ? 16 : 8;
  endfunction

  task automatic clkBit(input logic b);
    @(negedge clk) diIn = b;
    @(negedge clk) sclkIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    lastDo = (target == 1) ? doNarrow : doMain;
    sclkIn = 1'b0;
  endtask

  task automatic sendTop(input logic [63:0] v, input int n, input int k);
    for (int i = n - 1; i >= n - k; i--) clkBit(v[i]);
  endtask

  task automatic beginFrame(input logic org);
    @(negedge clk);
    orgPin = org;
    if (target == 1) csNarrow = 1'b1; else csMain = 1'b1;
    @(negedge clk);
  endtask

  task automatic endFrame;
    @(negedge clk);
    csMain = 1'b0; csNarrow = 1'b0; diIn = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [15:0] refRead(input logic org, input int addr);
    logic [15:0] w;
    if (org) return refMem[addr];
    w = refMem[addr >> 1];
    return (addr % 2 == 1) ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  task automatic modelStore(input logic org, input int addr, input logic [15:0] d);
    if (!refWel) return;
    if (org) refMem[addr] = d;
    else if (addr % 2 == 1) refMem[addr >> 1][15:8] = d[7:0];
    else refMem[addr >> 1][7:0] = d[7:0];
  endtask

  task automatic cmdRead(input logic org, input int addr, output logic [15:0] val);
    beginFrame(org);
    sendTop({61'd0, 3'b110}, 3, 3);
    sendTop(64'(addr), aw(org), aw(org));
    check("R5 dummy bit", {15'd0, lastDo}, 16'd0);
    val = '0;
    for (int i = 0; i < dw(org); i++) begin
      clkBit(1'b0);
      val = {val[14:0], lastDo};
    end
    endFrame();
  endtask

  task automatic checkRead(input string req, input logic org, input int addr);
    logic [15:0] v;
    cmdRead(org, addr, v);
    check(req, v, refRead(org, addr));
  endtask

  function automatic logic [63:0] writeFrame(input logic org, input int addr, input logic [15:0] d);
    return (64'd5 << (aw(org) + dw(org))) | (64'(addr) << dw(org)) |
           64'(org ? d : {8'h00, d[7:0]});
  endfunction

  task automatic cmdWrite(input logic org, input int addr, input logic [15:0] d, input int cut);
    int n = 3 + aw(org) + dw(org);
    beginFrame(org);
    sendTop(writeFrame(org, addr, d), n, n - cut);
    endFrame();
    if (cut == 0) modelStore(org, addr, d);
  endtask

  task automatic cmdErase(input logic org, input int addr);
    int n = 3 + aw(org);
    beginFrame(org);
    sendTop((64'd7 << aw(org)) | 64'(addr), n, n);
    endFrame();
    modelStore(org, addr, 16'hFFFF);
  endtask

  task automatic cmdSpecial(input logic org, input logic [1:0] sel, input logic [15:0] d, input int zeros);
    int dcw = aw(org) - 2;
    logic [63:0] f = (64'd4 << aw(org)) | (64'(sel) << dcw) | (64'h2A5 & ((64'd1 << dcw) - 1));
    int n = 3 + aw(org);
    if (sel == 2'b01) begin
      f = (f << dw(org)) | 64'(org ? d : {8'h00, d[7:0]});
      n += dw(org);
    end
    beginFrame(org);
    for (int i = 0; i < zeros; i++) clkBit(1'b0);
    sendTop(f, n, n);
    endFrame();
    if (target == 0) begin
      unique case (sel)
        2'b11: refWel = 1'b1;
        2'b00: refWel = 1'b0;
        2'b10: if (refWel) for (int i = 0; i < WORDS; i++) refMem[i] = 16'hFFFF;
        default: if (refWel) for (int i = 0; i < WORDS; i++) refMem[i] = org ? d : {d[7:0], d[7:0]};
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTotal++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nTotal - nFail, nTotal);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    refWel = 1'b0;
    for (int i = 0; i < WORDS; i++) refMem[i] = 16'hFFFF;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 output low", {15'd0, doMain}, 16'd0);
    checkRead("R1 word 0", 1'b1, 0);
    checkRead("R1 last word", 1'b1, WORDS - 1);
    checkRead("R1 last byte", 1'b0, 2 * WORDS - 1);

    // R10: latch closed after reset
    cmdWrite(1'b1, 5, 16'h1234, 0);
    checkRead("R10 write locked", 1'b1, 5);
    cmdSpecial(1'b1, 2'b01, 16'h0000, 0);
    checkRead("R10 fill locked", 1'b1, 9);

    // R2 leading zeros, R8 latch open with don't-care bits
    cmdSpecial(1'b1, 2'b11, 16'h0, 3);

    // R6 R3 R4 word sweep
    for (int a = 0; a < WORDS; a++) cmdWrite(1'b1, a, 16'(a * 16'h9E37) ^ 16'h5A5A, 0);
    for (int a = 0; a < WORDS; a++) checkRead("R6 word sweep", 1'b1, a);

    // R4 byte sweep
    for (int b = 0; b < 2 * WORDS; b += 3) cmdWrite(1'b0, b, 16'(b ^ 8'hC3), 0);
    for (int a = 0; a < WORDS; a++) checkRead("R4 word after bytes", 1'b1, a);
    for (int b = 0; b < 2 * WORDS; b++) checkRead("R4 byte read", 1'b0, b);

    // R7 erase one location
    cmdErase(1'b1, 10);
    checkRead("R7 erase word", 1'b1, 10);
    cmdErase(1'b0, 41);
    checkRead("R7 erase byte", 1'b1, 20);
    checkRead("R7 erase neighbour", 1'b1, 21);

    // R11 abort before final edge, then a clean frame
    cmdWrite(1'b1, 20, 16'hDEAD, 1);
    checkRead("R11 aborted write", 1'b1, 20);
    cmdWrite(1'b0, 7, 16'h00AB, 4);
    checkRead("R11 aborted byte", 1'b0, 7);
    cmdWrite(1'b1, 21, 16'hC0DE, 0);
    checkRead("R11 next frame", 1'b1, 21);

    // R12 extra clocks after completion
    beginFrame(1'b1);
    sendTop(writeFrame(1'b1, 22, 16'h4321), 25, 25);
    sendTop(writeFrame(1'b1, 23, 16'h8765), 25, 25);
    endFrame();
    modelStore(1'b1, 22, 16'h4321);
    checkRead("R12 first frame", 1'b1, 22);
    checkRead("R12 trailing ignored", 1'b1, 23);

    // R9 fill all
    cmdSpecial(1'b1, 2'b01, 16'hBEEF, 0);
    for (int a = 0; a < WORDS; a += 7) checkRead("R9 fill word", 1'b1, a);
    cmdSpecial(1'b0, 2'b01, 16'h007E, 0);
    for (int a = 0; a < WORDS; a++) checkRead("R9 fill byte", 1'b1, a);

    // R8 erase all
    cmdSpecial(1'b0, 2'b10, 16'h0, 0);
    for (int a = 0; a < WORDS; a += 5) checkRead("R8 erase all", 1'b1, a);

    // R8 close latch, R10 no effect afterwards
    cmdWrite(1'b1, 3, 16'h0F0F, 0);
    cmdSpecial(1'b1, 2'b00, 16'h0, 0);
    cmdWrite(1'b1, 4, 16'h1111, 0);
    checkRead("R10 write after close", 1'b1, 4);
    cmdErase(1'b1, 3);
    checkRead("R10 erase after close", 1'b1, 3);
    cmdSpecial(1'b1, 2'b10, 16'h0, 0);
    checkRead("R10 erase all after close", 1'b1, 3);

    // R13 narrow variant ignores the top address bit
    target = 1;
    cmdSpecial(1'b1, 2'b11, 16'h0, 0);
    cmdWrite(1'b1, 6'h25, 16'hA1B2, 0);
    cmdRead(1'b1, 6'h05, v);
    check("R13 word alias", v, 16'hA1B2);
    cmdWrite(1'b0, 7'h45, 16'h003C, 0);
    cmdRead(1'b0, 7'h05, v);
    check("R13 byte alias", v, 16'h003C);
    cmdRead(1'b1, 6'h02, v);
    check("R13 byte in word", v, 16'h3CFF);
    target = 0;

    finished = 1'b1;
    $display("%0d/%0d checks passed", nTotal - nFail, nTotal);
    $finish;
  end
endmodule